// File: doc/BRIEF.md
# Hot-Plug Slot Controller

This block holds the control and status register pair of a hot-plug-capable downstream or root port. It turns slot events into interrupts. Software reaches both registers through one 32-bit configuration window with byte enables: bytes 0-1 are the control register and bytes 2-3 are the status register. Three hardware inputs report slot activity: an attention-button press, a device insertion and a device removal.

An internal notify level summarises whether any enabled, supported event is pending. An interrupt is signalled only when that level changes. The change goes out as a one-cycle message pulse carrying the interrupt message number, steered to the MSI-X or MSI output by the enable inputs. When neither message mode is enabled, it drives a level-sensitive INTx output. Every control write completes immediately and raises the command-completed event. The interlock control bit always reads zero, and writing one to it toggles the interlock status bit.

Top module: `hpslot_ctrl`

## Requirements
- R1: After reset, `cfg_rdata` reads `32'h0000_03C0`. The status register (bits 31:16) is all zero, which releases the interlock. Control (bits 15:0) has all event and interrupt enables clear and both indicator fields (control bits 7:6 and 9:8) at the off code `2'b11`.
- R2: Control bits 0, 3, 4, 5 (attention, presence-changed, command-completed and hot-plug interrupt enables) and bits 6-9 (indicators) are writable per byte lane. All other control bits read zero.
- R3: A write with `cfg_be[0]` or `cfg_be[1]` set is one command and sets command-completed (status bit 4) in the same cycle it is applied.
- R4: Writing one to control bit 11 toggles interlock status (status bit 7). Control bit 11 always reads zero.
- R5: Status bits 0, 3 and 4 are write-one-to-clear through byte lane 2. Other status bits ignore writes.
- R6: When the interlock is released, an insertion sets presence state (status bit 6) and a removal clears it. Both set presence-changed (status bit 3). If both arrive in the same cycle, the insertion wins.
- R7: While interlock status is set, an insertion or removal leaves the status unchanged and pulses `hp_err` for one cycle.
- R8: A `btn_press` cycle sets attention-button-pressed (status bit 0).
- R9: The notify level is control bit 5 AND any of (status & control & `16'h0019`). When both message enables are low, any cycle that applies a control write, a status write or a new event makes `intx` equal the notify level. Otherwise `intx` holds.
- R10: When a control write or a newly set event changes the notify level, one pulse is sent. It goes on `msix_valid` if `msix_en` is set, otherwise on `msi_valid` if `msi_en` is set. `msg_vector` equals `msg_num` in that cycle.
- R11: Setting an event bit that is already set sends no message. A status-only write that changes the notify level sends no message.
- R12: Events raised while their enables are clear stay pending. A later control write that enables them raises the notify level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_be | input | 4 | Byte enables: 0-1 control, 2-3 status |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | {status, control} |
| btn_press | input | 1 | Attention-button pressed |
| dev_insert | input | 1 | Device inserted |
| dev_remove | input | 1 | Device removed |
| hp_err | output | 1 | Insertion/removal refused by interlock |
| msix_en | input | 1 | MSI-X mode enable |
| msi_en | input | 1 | MSI mode enable |
| msg_num | input | VEC_W | Interrupt message number |
| intx | output | 1 | Legacy interrupt level |
| msix_valid | output | 1 | MSI-X message pulse |
| msi_valid | output | 1 | MSI message pulse |
| msg_vector | output | VEC_W | Vector of the current pulse |

## Verification
The bench drives a control write whose data also carries the interlock bit. A design that stored that bit would read it back as one, and one that ignored it would leave interlock status still. It re-presses the button while the event is pending. A design without the novelty test would emit a duplicate message. It clears events with status-only writes while a message mode is active. A design that treated clears as commands would emit spurious messages or move `intx`. It also raises events with their enables off and enables them later, where a design that dropped pending events would never raise `intx`. Simultaneous insertion and removal, and refusals under interlock, are compared cycle by cycle against a behavioural model.

// File: rtl/hpslot_pkg.sv
package hpslot_pkg;
   localparam int SB_ABP  = 0;
   localparam int SB_PDC  = 3;
   localparam int SB_CC   = 4;
   localparam int SB_PDS  = 6;
   localparam int SB_EIS  = 7;
   localparam int CB_HPIE = 5;
   localparam int CB_EIC  = 11;
   localparam logic [15:0] EVT_MASK   = 16'h0019;
   localparam logic [15:0] CTRL_WMASK = 16'h03F9;
   localparam logic [15:0] CTRL_RST   = 16'h03C0;
endpackage

// File: rtl/hpslot_regs.sv
module hpslot_regs
   import hpslot_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_wr,
   input  logic [3:0]  cfg_be,
   input  logic [31:0] cfg_wdata,
   input  logic        btn_press,
   input  logic        dev_insert,
   input  logic        dev_remove,
   output logic [15:0] ctrl_q,
   output logic [15:0] sts_q,
   output logic        notify_d,
   output logic        trig,
   output logic        eval,
   output logic        hp_err
);
   localparam int LANES = 4;

   logic [31:0] lane_m;
   logic [15:0] ctrl_d, sts_d, sts_clr, w1c;
   logic        cmd, sts_touch, eic_hit, refuse, new_evt, hp_any;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_m[g*8 +: 8] = {8{cfg_wr & cfg_be[g]}};
   end

   assign cmd       = |lane_m[15:0];
   assign sts_touch = |lane_m[31:16];
   assign eic_hit   = lane_m[CB_EIC] & cfg_wdata[CB_EIC];
   assign w1c       = cfg_wdata[31:16] & lane_m[31:16] & EVT_MASK;
   assign hp_any    = dev_insert | dev_remove;
   assign refuse    = hp_any & sts_q[SB_EIS];
   assign ctrl_d    = (ctrl_q & ~(lane_m[15:0] & CTRL_WMASK))
                    | (cfg_wdata[15:0] & lane_m[15:0] & CTRL_WMASK);

   always_comb begin
      sts_clr = sts_q & ~w1c;
      sts_d   = sts_clr;
      new_evt = 1'b0;
      if (eic_hit) sts_d[SB_EIS] = ~sts_q[SB_EIS];
      if (cmd) sts_d[SB_CC] = 1'b1;
      if (btn_press) begin
         if (!sts_clr[SB_ABP]) new_evt = 1'b1;
         sts_d[SB_ABP] = 1'b1;
      end
      if (hp_any && !sts_q[SB_EIS]) begin
         if (!sts_clr[SB_PDC]) new_evt = 1'b1;
         sts_d[SB_PDC] = 1'b1;
         sts_d[SB_PDS] = dev_insert;
      end
   end

   assign trig     = cmd | new_evt;
   assign eval     = trig | sts_touch;
   assign notify_d = ctrl_d[CB_HPIE] & (|(sts_d & ctrl_d & EVT_MASK));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST;
         sts_q  <= '0;
         hp_err <= 1'b0;
      end else begin
         ctrl_q <= ctrl_d;
         sts_q  <= sts_d;
         hp_err <= refuse;
      end
   end

   AST_CMD_SETS_CC: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && (cfg_be[0] || cfg_be[1])) |=> sts_q[SB_CC]); // R3
   AST_EIC_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_be[1] && cfg_wdata[CB_EIC]) |=> (sts_q[SB_EIS] != $past(sts_q[SB_EIS]))); // R4
   AST_REFUSED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((dev_insert || dev_remove) && sts_q[SB_EIS]) |=> (hp_err && $stable(sts_q[SB_PDS]))); // R7
   AST_BTN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      btn_press |=> sts_q[SB_ABP]); // R8
endmodule

// File: rtl/hpslot_irq.sv
module hpslot_irq #(
   parameter int VEC_W         = 5,
   parameter bit VEC_ZERO_IDLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             notify_d,
   input  logic             trig,
   input  logic             eval,
   input  logic             msix_en,
   input  logic             msi_en,
   input  logic [VEC_W-1:0] msg_num,
   output logic             intx,
   output logic             msix_valid,
   output logic             msi_valid,
   output logic [VEC_W-1:0] msg_vector
);
   if (VEC_W < 1 || VEC_W > 11) begin : g_bad_vec
      $error("hpslot_irq: VEC_W must lie in 1..11");
   end

   logic notify_q, fire, legacy;

   assign legacy = ~msix_en & ~msi_en;
   assign fire   = trig & (notify_d != notify_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         notify_q   <= 1'b0;
         intx       <= 1'b0;
         msix_valid <= 1'b0;
         msi_valid  <= 1'b0;
      end else begin
         notify_q   <= notify_d;
         msix_valid <= fire & msix_en;
         msi_valid  <= fire & ~msix_en & msi_en;
         if (eval && legacy) intx <= notify_d;
      end
   end

   if (VEC_ZERO_IDLE) begin : g_vec_zero
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) msg_vector <= '0;
         else msg_vector <= (fire && !legacy) ? msg_num : '0;
      end
   end else begin : g_vec_hold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) msg_vector <= '0;
         else if (fire && !legacy) msg_vector <= msg_num;
      end
   end

   AST_MSI_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      msi_valid |-> !$past(msix_en)); // R10
   AST_MSG_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (msix_valid || msi_valid) |-> (notify_q != $past(notify_q))); // R11
   AST_INTX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(msix_en || msi_en) |-> $stable(intx)); // R9
endmodule

// File: rtl/hpslot_ctrl.sv
module hpslot_ctrl #(
   parameter int VEC_W         = 5,
   parameter bit VEC_ZERO_IDLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [3:0]       cfg_be,
   input  logic [31:0]      cfg_wdata,
   output logic [31:0]      cfg_rdata,
   input  logic             btn_press,
   input  logic             dev_insert,
   input  logic             dev_remove,
   output logic             hp_err,
   input  logic             msix_en,
   input  logic             msi_en,
   input  logic [VEC_W-1:0] msg_num,
   output logic             intx,
   output logic             msix_valid,
   output logic             msi_valid,
   output logic [VEC_W-1:0] msg_vector
);
   logic [15:0] ctrl_q, sts_q;
   logic        notify_d, trig, eval;

   hpslot_regs u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
      .cfg_wdata(cfg_wdata), .btn_press(btn_press), .dev_insert(dev_insert),
      .dev_remove(dev_remove), .ctrl_q(ctrl_q), .sts_q(sts_q),
      .notify_d(notify_d), .trig(trig), .eval(eval), .hp_err(hp_err)
   );

   hpslot_irq #(.VEC_W(VEC_W), .VEC_ZERO_IDLE(VEC_ZERO_IDLE)) u_irq (
      .clk(clk), .rst_n(rst_n), .notify_d(notify_d), .trig(trig), .eval(eval),
      .msix_en(msix_en), .msi_en(msi_en), .msg_num(msg_num), .intx(intx),
      .msix_valid(msix_valid), .msi_valid(msi_valid), .msg_vector(msg_vector)
   );

   assign cfg_rdata = {sts_q, ctrl_q};

   AST_EIC_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_be[1] && cfg_wdata[11]) |=> !cfg_rdata[11]); // R4
endmodule

// File: tb/hpslot_ctrl_tb.sv
module hpslot_ctrl_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b1;
   logic cfg_wr = 1'b0;
   logic [3:0] cfg_be = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic btn_press = 1'b0, dev_insert = 1'b0, dev_remove = 1'b0;
   logic hp_err, intx, msix_valid, msi_valid;
   logic msix_en = 1'b0, msi_en = 1'b0;
   logic [4:0] msg_num = 5'd0;
   logic [4:0] msg_vector;

   int checks = 0;
   int errors = 0;
   bit started = 1'b0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   hpslot_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .btn_press(btn_press),
      .dev_insert(dev_insert), .dev_remove(dev_remove), .hp_err(hp_err),
      .msix_en(msix_en), .msi_en(msi_en), .msg_num(msg_num), .intx(intx),
      .msix_valid(msix_valid), .msi_valid(msi_valid), .msg_vector(msg_vector)
   );

   // behavioural reference model
   logic [15:0] m_ctrl = 16'h03C0, m_sts = 16'h0000;
   bit m_notify = 0, m_intx = 0, m_msix = 0, m_msi = 0, m_err = 0;
   logic [4:0] m_vec = '0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ctrl = 16'h03C0; m_sts = 16'h0000;
         m_notify = 0; m_intx = 0; m_msix = 0; m_msi = 0; m_err = 0; m_vec = '0;
      end else begin
         logic [15:0] c, s;
         bit cmd, touch, trg, nn;
         c = m_ctrl; s = m_sts;
         cmd = cfg_wr && (cfg_be[0] || cfg_be[1]);
         touch = cfg_wr && (cfg_be[2] || cfg_be[3]);
         trg = cmd;
         m_err = (dev_insert || dev_remove) && m_sts[7];
         if (cfg_wr && cfg_be[0]) c[7:0] = cfg_wdata[7:0] & 8'hF9;
         if (cfg_wr && cfg_be[1]) begin
            c[15:8] = cfg_wdata[15:8] & 8'h03;
            if (cfg_wdata[11]) s[7] = ~s[7];
         end
         if (cfg_wr && cfg_be[2]) s[7:0] = s[7:0] & ~(cfg_wdata[23:16] & 8'h19);
         if (cmd) s[4] = 1'b1;
         if (btn_press) begin
            if (!s[0]) trg = 1;
            s[0] = 1'b1;
         end
         if ((dev_insert || dev_remove) && !m_sts[7]) begin
            if (!s[3]) trg = 1;
            s[3] = 1'b1;
            s[6] = dev_insert;
         end
         nn = c[5] && ((s & c & 16'h0019) != 0);
         m_msix = trg && (nn != m_notify) && msix_en;
         m_msi  = trg && (nn != m_notify) && !msix_en && msi_en;
         if (m_msix || m_msi) m_vec = msg_num;
         if ((trg || touch) && !msix_en && !msi_en) m_intx = nn;
         m_notify = nn;
         m_ctrl = c; m_sts = s;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) if (started) begin
      chk("R1 model rdata", cfg_rdata, {m_sts, m_ctrl});
      chk("R9 model intx", {31'd0, intx}, {31'd0, m_intx});
      chk("R10 model msix", {31'd0, msix_valid}, {31'd0, m_msix});
      chk("R10 model msi", {31'd0, msi_valid}, {31'd0, m_msi});
      chk("R7 model err", {31'd0, hp_err}, {31'd0, m_err});
      if (m_msix || m_msi) chk("R10 model vector", {27'd0, msg_vector}, {27'd0, m_vec});
   end

   task automatic cyc(input logic w, input logic [3:0] be, input logic [31:0] d,
                      input logic b, input logic i, input logic r);
      cfg_wr = w; cfg_be = be; cfg_wdata = d;
      btn_press = b; dev_insert = i; dev_remove = r;
      @(posedge clk); #2;
      cfg_wr = 0; cfg_be = '0; cfg_wdata = '0;
      btn_press = 0; dev_insert = 0; dev_remove = 0;
   endtask

   initial begin
      #1 rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #2 rst_n = 1'b1;
      started = 1'b1;
      chk("R1 reset value", cfg_rdata, 32'h0000_03C0);
      chk("R1 reset intx", {31'd0, intx}, 32'd0);
      // all-ones control write: mask, CC, interlock toggle
      cyc(1, 4'b0011, 32'h0000_FFFF, 0, 0, 0);
      chk("R2 writable control mask", {16'd0, cfg_rdata[15:0]}, 32'h0000_03F9);
      chk("R3 command completed", {16'd0, cfg_rdata[31:16]}, 32'h0000_0090);
      chk("R4 interlock toggled, bit 11 reads 0", {31'd0, cfg_rdata[11]}, 32'd0);
      chk("R9 intx follows notify", {31'd0, intx}, 32'd1);
      cyc(1, 4'b0100, 32'h00FF_0000, 0, 0, 0);
      chk("R5 w1c events only", {16'd0, cfg_rdata[31:16]}, 32'h0000_0080);
      chk("R9 intx dropped", {31'd0, intx}, 32'd0);
      cyc(0, 4'b0000, 32'h0, 0, 1, 0);
      chk("R7 refused err", {31'd0, hp_err}, 32'd1);
      chk("R7 refused status", {16'd0, cfg_rdata[31:16]}, 32'h0000_0080);
      cyc(1, 4'b0010, 32'h0000_0B00, 0, 0, 0);
      chk("R4 interlock released", {16'd0, cfg_rdata[31:16]}, 32'h0000_0010);
      cyc(1, 4'b0100, 32'h0010_0000, 0, 0, 0);
      cyc(0, 4'b0000, 32'h0, 0, 1, 0);
      chk("R6 insertion", {16'd0, cfg_rdata[31:16]}, 32'h0000_0048);
      chk("R6 insertion intx", {31'd0, intx}, 32'd1);
      cyc(0, 4'b0000, 32'h0, 1, 0, 0);
      chk("R8 button", {16'd0, cfg_rdata[31:16]}, 32'h0000_0049);
      // MSI-X mode
      msix_en = 1'b1; msg_num = 5'd21;
      cyc(1, 4'b0100, 32'h0019_0000, 0, 0, 0);
      chk("R11 status-only clear no msg", {31'd0, msix_valid}, 32'd0);
      chk("R9 intx holds in message mode", {31'd0, intx}, 32'd1);
      cyc(0, 4'b0000, 32'h0, 1, 0, 0);
      chk("R10 msix pulse", {31'd0, msix_valid}, 32'd1);
      chk("R10 msix vector", {27'd0, msg_vector}, 32'd21);
      cyc(0, 4'b0000, 32'h0, 0, 0, 0);
      chk("R10 one-cycle pulse", {31'd0, msix_valid}, 32'd0);
      cyc(0, 4'b0000, 32'h0, 1, 0, 0);
      chk("R11 re-set event no msg", {31'd0, msix_valid}, 32'd0);
      // MSI mode
      msix_en = 1'b0; msi_en = 1'b1; msg_num = 5'd9;
      cyc(1, 4'b0100, 32'h0001_0000, 0, 0, 0);
      chk("R11 clear in msi mode", {31'd0, msi_valid}, 32'd0);
      cyc(0, 4'b0000, 32'h0, 0, 0, 1);
      chk("R6 removal", {16'd0, cfg_rdata[31:16]}, 32'h0000_0008);
      chk("R10 msi pulse", {31'd0, msi_valid}, 32'd1);
      chk("R10 msi vector", {27'd0, msg_vector}, 32'd9);
      chk("R10 msix idle", {31'd0, msix_valid}, 32'd0);
      // pending while disabled
      cyc(1, 4'b0001, 32'h0000_00C0, 0, 0, 0);
      chk("R2 enables cleared", {16'd0, cfg_rdata[15:0]}, 32'h0000_03C0);
      msi_en = 1'b0;
      cyc(0, 4'b0000, 32'h0, 1, 0, 0);
      chk("R12 pending no intx", {31'd0, intx}, 32'd0);
      cyc(1, 4'b0001, 32'h0000_00E1, 0, 0, 0);
      chk("R12 enable raises intx", {31'd0, intx}, 32'd1);
      cyc(0, 4'b0000, 32'h0, 0, 1, 1);
      chk("R6 insert wins", {16'd0, cfg_rdata[31:16]}, 32'h0000_0059);
      // reset releases interlock
      cyc(1, 4'b0010, 32'h0000_0B00, 0, 0, 0);
      chk("R4 interlock set", {31'd0, cfg_rdata[23]}, 32'd1);
      rst_n = 1'b0;
      @(posedge clk); #2 rst_n = 1'b1;
      chk("R1 reset mid-run", cfg_rdata, 32'h0000_03C0);
      cyc(0, 4'b0000, 32'h0, 0, 0, 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule